// File: doc/BRIEF.md
# Program-Derived Register-Transfer Datapath

This block is the register-transfer half of a program that has been turned straight into hardware. Each scalar variable of the program is one register, and each array is a small RAM. Every storage element has a data-source multiplexer whose inputs are exactly the right-hand sides assigned to it. Each RAM also has an address multiplexer fed by the subscript expressions used with that array. Only one copy of each arithmetic expression exists, and every statement that needs it shares that copy.

An external sequencer, which is not part of this block, runs the program. In each clock cycle it sets the encoded selects and fires the load or write strobes for the one statement it executes. It reads back the boolean test results and the register values. The datapath holds four scalars: `p`, `q`, `k` and `acc`. It also holds two 16-entry RAMs, `u` and `v`. Two statements are supported in one cycle each: u[p] = v[q] + k and u[v[p]] = q. Both work because the RAM read is combinational and feeds the other RAM's write data or address without an extra cycle.

Top module: `rt_datapath`

## Requirements
- R1: An active-low asynchronous reset clears p, q, k, acc and every entry of both RAMs to 0.
- R2: p loads on p_ld_i from p_sel_i (0 = external data, 1 = p+1). q loads on q_ld_i from q_sel_i (0 = external data, 1 = acc). k loads external data on k_ld_i. A register whose strobe is low keeps its value, whatever its select is.
- R3: acc loads on acc_ld_i from acc_sel_i: 0 = p+q, 1 = p, 2 = q-p, 3 = p+q. Arithmetic wraps modulo 256.
- R4: The u address comes from u_asel_i (0 = p+q, 1 = p, 2 = q-p, 3 = current v read value). Both RAMs use only the low 4 bits of the selected subscript.
- R5: u is written at the clock edge only when u_we_i is high. The write data comes from u_dsel_i: 0 = v read value + k, 1 = q, 2 = external data, 3 = v read value + k.
- R6: The v address comes from v_asel_i (0 = p, 1 = q, 2 = p+1, 3 = p). v write data comes from v_dsel_i (0 = external data, 1 = acc). v is written only when v_we_i is high.
- R7: Both RAM reads are combinational. u_rd_o and v_rd_o show the addressed entry in the same cycle, so a v read can act as the u write address of the same statement.
- R8: v_nz_o is 1 exactly when the current v read value is nonzero.
- R9: acc_zero_o is 1 exactly when acc is 0. acc_neg_o equals bit 7 of acc.
- R10: acc_match_o is 1 exactly when acc equals the constant MATCH_VAL (default 8'hA5).
- R11: pq_eq_o is 1 exactly when p equals q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_data_i | input | 8 | External data source |
| p_ld_i | input | 1 | Load strobe for p |
| p_sel_i | input | 1 | p source select |
| q_ld_i | input | 1 | Load strobe for q |
| q_sel_i | input | 1 | q source select |
| k_ld_i | input | 1 | Load strobe for k |
| acc_ld_i | input | 1 | Load strobe for acc |
| acc_sel_i | input | 2 | acc source select |
| u_we_i | input | 1 | u write strobe |
| u_dsel_i | input | 2 | u write-data select |
| u_asel_i | input | 2 | u address select |
| v_we_i | input | 1 | v write strobe |
| v_dsel_i | input | 1 | v write-data select |
| v_asel_i | input | 2 | v address select |
| p_o | output | 8 | Value of p |
| q_o | output | 8 | Value of q |
| k_o | output | 8 | Value of k |
| acc_o | output | 8 | Value of acc |
| u_rd_o | output | 8 | u read value at the selected address |
| v_rd_o | output | 8 | v read value at the selected address |
| v_nz_o | output | 1 | v read value is nonzero |
| acc_zero_o | output | 1 | acc is zero |
| acc_neg_o | output | 1 | acc sign bit |
| acc_match_o | output | 1 | acc equals MATCH_VAL |
| pq_eq_o | output | 1 | p equals q |

## Verification
Every select code of every multiplexer is driven at least once, each with operands that give different results for different codes. For example, with p=3 and q=10, the sums, differences and pass-throughs all differ, so a swapped mux input shows up. Operand pairs that overflow and underflow, and subscripts with upper bits set, separate correct modulo-256 wrapping and 4-bit address truncation from wider or misaligned logic. Cycles that change every select while all strobes stay low, followed by read-back through the address muxes, show that nothing moves without its strobe. Chained statements, where a v read supplies the u data or address, separate a combinational read port from a registered one.

// File: rtl/rt_datapath_pkg.sv
package rt_datapath_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 4;

  // mux input indices; codes beyond the last index fall back to index 0
  localparam int unsigned P_EXT = 0;
  localparam int unsigned P_INC = 1;
  localparam int unsigned P_NSRC = 2;

  localparam int unsigned Q_EXT = 0;
  localparam int unsigned Q_ACC = 1;
  localparam int unsigned Q_NSRC = 2;

  localparam int unsigned ACC_SUM = 0;
  localparam int unsigned ACC_P = 1;
  localparam int unsigned ACC_DIFF = 2;
  localparam int unsigned ACC_NSRC = 3;

  localparam int unsigned UA_SUM = 0;
  localparam int unsigned UA_P = 1;
  localparam int unsigned UA_DIFF = 2;
  localparam int unsigned UA_VRD = 3;
  localparam int unsigned UA_NSRC = 4;

  localparam int unsigned UD_VK = 0;
  localparam int unsigned UD_Q = 1;
  localparam int unsigned UD_EXT = 2;
  localparam int unsigned UD_NSRC = 3;

  localparam int unsigned VA_P = 0;
  localparam int unsigned VA_Q = 1;
  localparam int unsigned VA_INC = 2;
  localparam int unsigned VA_NSRC = 3;

  localparam int unsigned VD_EXT = 0;
  localparam int unsigned VD_ACC = 1;
  localparam int unsigned VD_NSRC = 2;
endpackage

// File: rtl/rt_sel_mux.sv
module rt_sel_mux #(
  parameter int unsigned N  = 2,
  parameter int unsigned W  = 8,
  parameter int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][W-1:0] src_i,
  input  logic [SW-1:0]       sel_i,
  output logic [W-1:0]        dout_o
);
  always_comb begin
    dout_o = src_i[0];
    for (int n = 1; n < int'(N); n++) begin
      if (sel_i == SW'(n)) dout_o = src_i[n];
    end
  end
endmodule

// File: rtl/rt_reg.sv
module rt_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/rt_ram.sv
module rt_ram #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0]     mem_q [DEPTH];
  logic [DEPTH-1:0] hit;

  for (genvar e = 0; e < DEPTH; e++) begin : g_dec
    assign hit[e] = we_i && (addr_i == AW'(e));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < int'(DEPTH); e++) mem_q[e] <= '0;
    end else begin
      for (int e = 0; e < int'(DEPTH); e++) begin
        if (hit[e]) mem_q[e] <= wdata_i;
      end
    end
  end

  // single port, combinational read
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/rt_flags.sv
module rt_flags #(
  parameter int unsigned   W     = 8,
  parameter logic [W-1:0]  MATCH = '0
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] rd_i,
  output logic         rd_nz_o,
  output logic         acc_zero_o,
  output logic         acc_neg_o,
  output logic         acc_match_o,
  output logic         pq_eq_o
);
  logic [W-1:0] match_bit;
  logic [W-1:0] diff_bit;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // constant compare: invert only where the constant bit is 0
    if (MATCH[b]) begin : g_one
      assign match_bit[b] = acc_i[b];
    end else begin : g_zero
      assign match_bit[b] = ~acc_i[b];
    end
    assign diff_bit[b] = p_i[b] ^ q_i[b];
  end

  assign acc_zero_o  = &(~acc_i);
  assign acc_neg_o   = acc_i[W-1];
  assign acc_match_o = &match_bit;
  assign pq_eq_o     = ~|diff_bit;
  assign rd_nz_o     = |rd_i;
endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import rt_datapath_pkg::*;
#(
  parameter int unsigned  DW        = DATA_W,
  parameter int unsigned  AW        = ADDR_W,
  parameter logic [DW-1:0] MATCH_VAL = DW'('hA5)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ext_data_i,
  input  logic          p_ld_i,
  input  logic          p_sel_i,
  input  logic          q_ld_i,
  input  logic          q_sel_i,
  input  logic          k_ld_i,
  input  logic          acc_ld_i,
  input  logic [1:0]    acc_sel_i,
  input  logic          u_we_i,
  input  logic [1:0]    u_dsel_i,
  input  logic [1:0]    u_asel_i,
  input  logic          v_we_i,
  input  logic          v_dsel_i,
  input  logic [1:0]    v_asel_i,
  output logic [DW-1:0] p_o,
  output logic [DW-1:0] q_o,
  output logic [DW-1:0] k_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] u_rd_o,
  output logic [DW-1:0] v_rd_o,
  output logic          v_nz_o,
  output logic          acc_zero_o,
  output logic          acc_neg_o,
  output logic          acc_match_o,
  output logic          pq_eq_o
);
  logic [DW-1:0] p_q, q_q, k_q, acc_q, u_rd, v_rd;

  // shared expression hardware, one instance each
  logic [DW-1:0] sum_pq, diff_qp, inc_p, sum_vk;
  assign sum_pq  = p_q + q_q;
  assign diff_qp = q_q - p_q;
  assign inc_p   = p_q + DW'(1);
  assign sum_vk  = v_rd + k_q;

  // p
  logic [P_NSRC-1:0][DW-1:0] p_src;
  logic [DW-1:0]             p_d;
  assign p_src[P_EXT] = ext_data_i;
  assign p_src[P_INC] = inc_p;
  rt_sel_mux #(.N(P_NSRC), .W(DW)) u_p_mux (.src_i(p_src), .sel_i(p_sel_i), .dout_o(p_d));
  rt_reg #(.W(DW)) u_p_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(p_ld_i), .d_i(p_d), .q_o(p_q)
  );

  // q
  logic [Q_NSRC-1:0][DW-1:0] q_src;
  logic [DW-1:0]             q_d;
  assign q_src[Q_EXT] = ext_data_i;
  assign q_src[Q_ACC] = acc_q;
  rt_sel_mux #(.N(Q_NSRC), .W(DW)) u_q_mux (.src_i(q_src), .sel_i(q_sel_i), .dout_o(q_d));
  rt_reg #(.W(DW)) u_q_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(q_ld_i), .d_i(q_d), .q_o(q_q)
  );

  // k: single source, no mux
  rt_reg #(.W(DW)) u_k_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(k_ld_i), .d_i(ext_data_i), .q_o(k_q)
  );

  // acc
  logic [ACC_NSRC-1:0][DW-1:0] acc_src;
  logic [DW-1:0]               acc_d;
  assign acc_src[ACC_SUM]  = sum_pq;
  assign acc_src[ACC_P]    = p_q;
  assign acc_src[ACC_DIFF] = diff_qp;
  rt_sel_mux #(.N(ACC_NSRC), .W(DW)) u_acc_mux (
    .src_i(acc_src), .sel_i(acc_sel_i), .dout_o(acc_d)
  );
  rt_reg #(.W(DW)) u_acc_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(acc_ld_i), .d_i(acc_d), .q_o(acc_q)
  );

  // v RAM
  logic [VA_NSRC-1:0][AW-1:0] va_src;
  logic [VD_NSRC-1:0][DW-1:0] vd_src;
  logic [AW-1:0]              v_addr;
  logic [DW-1:0]              v_wdata;
  assign va_src[VA_P]   = p_q[AW-1:0];
  assign va_src[VA_Q]   = q_q[AW-1:0];
  assign va_src[VA_INC] = inc_p[AW-1:0];
  assign vd_src[VD_EXT] = ext_data_i;
  assign vd_src[VD_ACC] = acc_q;
  rt_sel_mux #(.N(VA_NSRC), .W(AW)) u_va_mux (.src_i(va_src), .sel_i(v_asel_i), .dout_o(v_addr));
  rt_sel_mux #(.N(VD_NSRC), .W(DW)) u_vd_mux (.src_i(vd_src), .sel_i(v_dsel_i), .dout_o(v_wdata));
  rt_ram #(.W(DW), .AW(AW)) u_v_ram (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(v_we_i),
    .addr_i(v_addr), .wdata_i(v_wdata), .rdata_o(v_rd)
  );

  // u RAM; its address may come from the v read in the same cycle
  logic [UA_NSRC-1:0][AW-1:0] ua_src;
  logic [UD_NSRC-1:0][DW-1:0] ud_src;
  logic [AW-1:0]              u_addr;
  logic [DW-1:0]              u_wdata;
  assign ua_src[UA_SUM]  = sum_pq[AW-1:0];
  assign ua_src[UA_P]    = p_q[AW-1:0];
  assign ua_src[UA_DIFF] = diff_qp[AW-1:0];
  assign ua_src[UA_VRD]  = v_rd[AW-1:0];
  assign ud_src[UD_VK]   = sum_vk;
  assign ud_src[UD_Q]    = q_q;
  assign ud_src[UD_EXT]  = ext_data_i;
  rt_sel_mux #(.N(UA_NSRC), .W(AW)) u_ua_mux (.src_i(ua_src), .sel_i(u_asel_i), .dout_o(u_addr));
  rt_sel_mux #(.N(UD_NSRC), .W(DW)) u_ud_mux (.src_i(ud_src), .sel_i(u_dsel_i), .dout_o(u_wdata));
  rt_ram #(.W(DW), .AW(AW)) u_u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(u_we_i),
    .addr_i(u_addr), .wdata_i(u_wdata), .rdata_o(u_rd)
  );

  rt_flags #(.W(DW), .MATCH(MATCH_VAL)) u_flags (
    .acc_i(acc_q), .p_i(p_q), .q_i(q_q), .rd_i(v_rd),
    .rd_nz_o(v_nz_o), .acc_zero_o(acc_zero_o), .acc_neg_o(acc_neg_o),
    .acc_match_o(acc_match_o), .pq_eq_o(pq_eq_o)
  );

  assign p_o    = p_q;
  assign q_o    = q_q;
  assign k_o    = k_q;
  assign acc_o  = acc_q;
  assign u_rd_o = u_rd;
  assign v_rd_o = v_rd;
endmodule

// File: rtl/rt_datapath_chk.sv
module rt_datapath_chk #(
  parameter int unsigned   DW        = 8,
  parameter logic [DW-1:0] MATCH_VAL = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] ext_data_i,
  input logic          p_ld_i,
  input logic          k_ld_i,
  input logic          acc_ld_i,
  input logic [1:0]    acc_sel_i,
  input logic [DW-1:0] p_o,
  input logic [DW-1:0] q_o,
  input logic [DW-1:0] k_o,
  input logic [DW-1:0] acc_o,
  input logic [DW-1:0] v_rd_o,
  input logic          v_nz_o,
  input logic          acc_zero_o,
  input logic          acc_match_o,
  input logic          pq_eq_o
);
  a_r2_p_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_ld_i |=> $stable(p_o));

  a_r2_k_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_ld_i |=> (k_o == $past(ext_data_i)));

  a_r3_acc_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ld_i && acc_sel_i == 2'd0) |=> (acc_o == DW'($past(p_o) + $past(q_o))));

  a_r3_acc_diff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ld_i && acc_sel_i == 2'd2) |=> (acc_o == DW'($past(q_o) - $past(p_o))));

  a_r8_v_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_nz_o == (v_rd_o != '0));

  a_r9_acc_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_zero_o == (acc_o == '0));

  a_r10_acc_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_match_o == (acc_o == MATCH_VAL));

  a_r11_pq_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pq_eq_o == (p_o == q_o));
endmodule

bind rt_datapath rt_datapath_chk #(.DW(DW), .MATCH_VAL(MATCH_VAL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ext_data_i(ext_data_i),
  .p_ld_i(p_ld_i), .k_ld_i(k_ld_i), .acc_ld_i(acc_ld_i), .acc_sel_i(acc_sel_i),
  .p_o(p_o), .q_o(q_o), .k_o(k_o), .acc_o(acc_o), .v_rd_o(v_rd_o),
  .v_nz_o(v_nz_o), .acc_zero_o(acc_zero_o), .acc_match_o(acc_match_o),
  .pq_eq_o(pq_eq_o)
);

// File: tb/rt_datapath_test.sv
`timescale 1ns/1ps
module rt_datapath_test;
  localparam logic [7:0] MATCH = 8'hA5;

  typedef struct {
    logic [7:0] ext;
    logic p_ld, p_sel, q_ld, q_sel, k_ld, acc_ld;
    logic [1:0] acc_sel;
    logic u_we;
    logic [1:0] u_dsel, u_asel;
    logic v_we, v_dsel;
    logic [1:0] v_asel;
  } ctrl_t;

  typedef struct packed {
    logic [7:0] p, q, k, acc, u_rd, v_rd;
    logic v_nz, acc_zero, acc_neg, acc_match, pq_eq;
  } obs_t;

  typedef struct {
    obs_t  o;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] ext_data;
  logic p_ld, p_sel, q_ld, q_sel, k_ld, acc_ld, u_we, v_we, v_dsel;
  logic [1:0] acc_sel, u_dsel, u_asel, v_asel;
  logic [7:0] p_o, q_o, k_o, acc_o, u_rd_o, v_rd_o;
  logic v_nz_o, acc_zero_o, acc_neg_o, acc_match_o, pq_eq_o;

  always #2 clk = ~clk;

  rt_datapath uut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_data_i(ext_data),
    .p_ld_i(p_ld), .p_sel_i(p_sel), .q_ld_i(q_ld), .q_sel_i(q_sel),
    .k_ld_i(k_ld), .acc_ld_i(acc_ld), .acc_sel_i(acc_sel),
    .u_we_i(u_we), .u_dsel_i(u_dsel), .u_asel_i(u_asel),
    .v_we_i(v_we), .v_dsel_i(v_dsel), .v_asel_i(v_asel),
    .p_o(p_o), .q_o(q_o), .k_o(k_o), .acc_o(acc_o),
    .u_rd_o(u_rd_o), .v_rd_o(v_rd_o), .v_nz_o(v_nz_o),
    .acc_zero_o(acc_zero_o), .acc_neg_o(acc_neg_o),
    .acc_match_o(acc_match_o), .pq_eq_o(pq_eq_o)
  );

  // reference state
  logic [7:0] m_p, m_q, m_k, m_acc;
  logic [7:0] m_u [16];
  logic [7:0] m_v [16];
  item_t exp_q [$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic ctrl_t idle();
    ctrl_t c;
    c.ext = 8'h00; c.p_ld = 0; c.p_sel = 0; c.q_ld = 0; c.q_sel = 0;
    c.k_ld = 0; c.acc_ld = 0; c.acc_sel = 0; c.u_we = 0; c.u_dsel = 0;
    c.u_asel = 0; c.v_we = 0; c.v_dsel = 0; c.v_asel = 0;
    return c;
  endfunction

  function automatic logic [7:0] m_vaddr(ctrl_t c);
    case (c.v_asel)
      2'd1:    return m_q;
      2'd2:    return m_p + 8'd1;
      default: return m_p;
    endcase
  endfunction

  function automatic logic [7:0] m_vrd(ctrl_t c);
    logic [7:0] a = m_vaddr(c);
    return m_v[a[3:0]];
  endfunction

  function automatic logic [7:0] m_uaddr(ctrl_t c);
    case (c.u_asel)
      2'd0:    return m_p + m_q;
      2'd1:    return m_p;
      2'd2:    return m_q - m_p;
      default: return m_vrd(c);
    endcase
  endfunction

  function automatic obs_t m_obs(ctrl_t c);
    obs_t o;
    logic [7:0] ua = m_uaddr(c);
    o.p = m_p; o.q = m_q; o.k = m_k; o.acc = m_acc;
    o.v_rd = m_vrd(c);
    o.u_rd = m_u[ua[3:0]];
    o.v_nz = (o.v_rd != 0);
    o.acc_zero = (m_acc == 0);
    o.acc_neg = m_acc[7];
    o.acc_match = (m_acc == MATCH);
    o.pq_eq = (m_p == m_q);
    return o;
  endfunction

  task automatic m_step(ctrl_t c);
    logic [7:0] np, nq, nacc, ud, vd, ua, va, vr;
    np = c.p_sel ? m_p + 8'd1 : c.ext;
    nq = c.q_sel ? m_acc : c.ext;
    case (c.acc_sel)
      2'd1:    nacc = m_p;
      2'd2:    nacc = m_q - m_p;
      default: nacc = m_p + m_q;
    endcase
    vr = m_vrd(c);
    case (c.u_dsel)
      2'd1:    ud = m_q;
      2'd2:    ud = c.ext;
      default: ud = vr + m_k;
    endcase
    vd = c.v_dsel ? m_acc : c.ext;
    ua = m_uaddr(c);
    va = m_vaddr(c);
    if (c.u_we) m_u[ua[3:0]] = ud;
    if (c.v_we) m_v[va[3:0]] = vd;
    if (c.p_ld) m_p = np;
    if (c.q_ld) m_q = nq;
    if (c.k_ld) m_k = c.ext;
    if (c.acc_ld) m_acc = nacc;
  endtask

  task automatic apply(ctrl_t c);
    ext_data = c.ext; p_ld = c.p_ld; p_sel = c.p_sel; q_ld = c.q_ld;
    q_sel = c.q_sel; k_ld = c.k_ld; acc_ld = c.acc_ld; acc_sel = c.acc_sel;
    u_we = c.u_we; u_dsel = c.u_dsel; u_asel = c.u_asel;
    v_we = c.v_we; v_dsel = c.v_dsel; v_asel = c.v_asel;
  endtask

  task automatic m_clear();
    m_p = 0; m_q = 0; m_k = 0; m_acc = 0;
    for (int e = 0; e < 16; e++) begin m_u[e] = 0; m_v[e] = 0; end
  endtask

  // driver: one statement per cycle, expected outputs after its edge
  task automatic run(ctrl_t c, string tag);
    item_t it;
    @(negedge clk); #1;
    apply(c);
    m_step(c);
    it.o = m_obs(c);
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        item_t it;
        obs_t got;
        it = exp_q.pop_front();
        got = '{p_o, q_o, k_o, acc_o, u_rd_o, v_rd_o,
                v_nz_o, acc_zero_o, acc_neg_o, acc_match_o, pq_eq_o};
        checks++;
        if (got !== it.o) begin
          errors++;
          $display("FAIL %s got p=%h q=%h k=%h acc=%h u=%h v=%h fl=%b exp p=%h q=%h k=%h acc=%h u=%h v=%h fl=%b",
                   it.tag, got.p, got.q, got.k, got.acc, got.u_rd, got.v_rd,
                   {got.v_nz, got.acc_zero, got.acc_neg, got.acc_match, got.pq_eq},
                   it.o.p, it.o.q, it.o.k, it.o.acc, it.o.u_rd, it.o.v_rd,
                   {it.o.v_nz, it.o.acc_zero, it.o.acc_neg, it.o.acc_match, it.o.pq_eq});
        end
      end
    end
  end

  initial begin
    #600us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ctrl_t c;
    m_clear();
    apply(idle());
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    run(idle(), "R1");                                  // reset state

    c = idle(); c.ext = 8'd3;  c.p_ld = 1; run(c, "R2");
    c = idle(); c.ext = 8'd10; c.q_ld = 1; run(c, "R2");
    c = idle(); c.ext = 8'd7;  c.k_ld = 1; run(c, "R2");

    c = idle(); c.acc_ld = 1; c.acc_sel = 0; run(c, "R3");
    c = idle(); c.acc_ld = 1; c.acc_sel = 1; run(c, "R3");
    c = idle(); c.acc_ld = 1; c.acc_sel = 2; run(c, "R3");
    c = idle(); c.acc_ld = 1; c.acc_sel = 3; run(c, "R3");

    // v writes with each address/data source
    c = idle(); c.ext = 8'h11; c.v_we = 1; c.v_asel = 0; c.v_dsel = 0; run(c, "R6");
    c = idle(); c.v_we = 1; c.v_asel = 1; c.v_dsel = 1; run(c, "R6");
    c = idle(); c.ext = 8'h22; c.v_we = 1; c.v_asel = 2; run(c, "R6");
    c = idle(); c.v_asel = 2; run(c, "R8");
    c = idle(); c.v_asel = 3; run(c, "R6");
    c = idle(); c.v_asel = 1; run(c, "R7");

    // u[p] = v[q] + k
    c = idle(); c.u_we = 1; c.u_dsel = 0; c.u_asel = 1; c.v_asel = 1; run(c, "R5");
    // u[v[p]] = q
    c = idle(); c.u_we = 1; c.u_dsel = 1; c.u_asel = 3; c.v_asel = 0; run(c, "R7");
    c = idle(); c.u_asel = 3; c.v_asel = 0; run(c, "R7");
    c = idle(); c.ext = 8'h5A; c.u_we = 1; c.u_dsel = 2; c.u_asel = 0; run(c, "R4");
    c = idle(); c.ext = 8'h6B; c.u_we = 1; c.u_dsel = 2; c.u_asel = 2; run(c, "R4");
    c = idle(); c.u_we = 1; c.u_dsel = 3; c.u_asel = 1; c.v_asel = 2; run(c, "R5");

    // strobes low: nothing may change
    c = idle(); c.ext = 8'hFF; c.p_sel = 1; c.q_sel = 1; c.acc_sel = 2;
    c.u_dsel = 2; c.u_asel = 2; c.v_dsel = 1; c.v_asel = 2; run(c, "R2");
    c = idle(); c.ext = 8'hEE; c.u_asel = 0; c.v_asel = 1; run(c, "R5");
    c = idle(); c.u_asel = 1; c.v_asel = 0; run(c, "R6");

    c = idle(); c.p_ld = 1; c.p_sel = 1; run(c, "R2");
    c = idle(); c.q_ld = 1; c.q_sel = 1; run(c, "R2");
    c = idle(); c.v_asel = 1; run(c, "R8");

    // wrap and sign
    c = idle(); c.ext = 8'd200; c.p_ld = 1; run(c, "R3");
    c = idle(); c.ext = 8'd100; c.q_ld = 1; run(c, "R3");
    c = idle(); c.acc_ld = 1; c.acc_sel = 0; run(c, "R3");
    c = idle(); c.acc_ld = 1; c.acc_sel = 2; run(c, "R9");
    c = idle(); c.ext = 8'd100; c.p_ld = 1; run(c, "R11");
    c = idle(); c.acc_ld = 1; c.acc_sel = 2; run(c, "R9");

    // constant compare
    c = idle(); c.ext = 8'hA0; c.p_ld = 1; run(c, "R10");
    c = idle(); c.ext = 8'h05; c.q_ld = 1; run(c, "R10");
    c = idle(); c.acc_ld = 1; c.acc_sel = 0; run(c, "R10");
    c = idle(); c.ext = 8'h04; c.q_ld = 1; c.acc_ld = 1; c.acc_sel = 0; run(c, "R10");
    c = idle(); c.acc_ld = 1; c.acc_sel = 0; run(c, "R10");

    // upper subscript bits ignored
    c = idle(); c.ext = 8'h13; c.p_ld = 1; run(c, "R4");
    c = idle(); c.ext = 8'h77; c.v_we = 1; c.v_asel = 0; c.u_we = 1; c.u_dsel = 2; c.u_asel = 1; run(c, "R4");
    c = idle(); c.ext = 8'h03; c.p_ld = 1; run(c, "R4");
    c = idle(); c.v_asel = 0; c.u_asel = 1; run(c, "R4");
    c = idle(); c.ext = 8'h0F; c.p_ld = 1; run(c, "R8");
    c = idle(); c.v_asel = 2; run(c, "R8");

    // asynchronous reset mid-run
    begin
      item_t it;
      @(negedge clk); #1;
      apply(idle());
      rst_ni = 1'b0;
      m_clear();
      it.o = m_obs(idle());
      it.tag = "R1";
      exp_q.push_back(it);
      @(negedge clk); #1;
      rst_ni = 1'b1;
    end
    c = idle(); c.u_asel = 2; c.v_asel = 1; run(c, "R1");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule